// File: doc/BRIEF.md
# Prioritized Nesting Interrupt Controller

This block gathers a fixed set of level-sensitive interrupt request lines and forwards one interrupt request to a small processor. Each line can be blocked by its own bit in a mask register. Of the lines that are raised and not blocked, the lowest-numbered one wins. Its index, together with a valid flag, can be read from a vector register.

The controller also keeps an in-service register with one bit per priority level. When software writes the acknowledge register, the bit of the current winner is set. From then on, only requests whose priority is strictly above every level in service can reach the processor. Writing the end-of-interrupt register clears the highest-priority bit in service and so returns to the previous level. Nested handlers therefore never have to rewrite the mask.

A small state machine tracks the depth of service. It has three states: ST_IDLE (nothing in service), ST_ACTIVE (one level in service) and ST_NESTED (two or more levels). Its transitions are:
- ACK_FIRST: from ST_IDLE to ST_ACTIVE.
- ACK_NEST: from ST_ACTIVE to ST_NESTED, and from ST_NESTED back to itself.
- EOI_LAST: from ST_ACTIVE to ST_IDLE.
- EOI_UNNEST: from ST_NESTED to ST_ACTIVE when two levels were in service, otherwise staying in ST_NESTED.

An end-of-interrupt write in ST_IDLE is ignored.

Top module: `pic_nest_ctrl`

## Requirements
- R1: After reset the mask register reads 8'hFF (all sources blocked), the in-service register reads 0, the vector register reads 0 and `cpu_irq` is low.
- R2: A source whose mask bit is 1 never wins and never raises `cpu_irq`, whatever its request line does.
- R3: The vector register (address 1) reads {valid, 4'b0, index[2:0]}: bit 7 is 1 and bits 2:0 hold the lowest-numbered qualifying source, or the whole byte is 0 when nothing qualifies. Source 0 has the highest priority.
- R4: A write to address 2 with data bit 0 = 1 sets the in-service bit of the source that wins at that clock edge. Such a write changes nothing when nothing qualifies, and a write to address 2 with bit 0 = 0 is ignored.
- R5: A raised, unmasked source qualifies only if its index is strictly lower than the index of every bit set in the in-service register. A source at the same level as one in service, or at a lower level, does not qualify.
- R6: `cpu_irq` is high exactly when some source qualifies, in the same cycle.
- R7: A write to address 3 with data bit 0 = 1 clears the lowest-indexed set bit of the in-service register. The write has no effect when that register is 0.
- R8: Nesting works without mask writes: a higher source preempts an acknowledged one, and after its end-of-interrupt the earlier level is still in service. The mask register is left unchanged throughout.
- R9: The register port is synchronous. With `bus_rd` high at a clock edge, `bus_rdata` holds after that edge the selected register as it was at that edge: address 0 returns the mask, address 1 the vector, address 2 the in-service register and address 3 returns 0. A write to address 0 loads the mask from `bus_wdata`.
- R10: If a request line rises in the same cycle that an acknowledge is written, the acknowledge takes the winner that includes that new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 8 | Level-sensitive request lines, bit 0 highest priority |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 mask, 1 vector, 2 acknowledge / in-service, 3 end-of-interrupt |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
An acknowledge write and a change on the request lines can fall in the same clock edge. The acknowledge then has to capture the winner as it stands at that edge, new request included. The bench provokes this by raising source 0 on the same falling edge on which it starts the acknowledge write, while only source 5 was pending before. It judges the result by reading back the in-service register: 8'h01 is expected, not 8'h20. Deep nesting is also run through all three service states, and the in-service and vector readbacks are checked after every end-of-interrupt.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        REG_MASK   = 2'd0,
        REG_VECTOR = 2'd1,
        REG_ACK    = 2'd2,
        REG_EOI    = 2'd3
    } pic_reg_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_NESTED = 2'd2
    } svc_state_e;

endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             found
);

    // lowest index wins: scan from the top so lower indices overwrite
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pic_svc_track.sv
module pic_svc_track
    import pic_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_go,
    input  logic             eoi_go,
    input  logic             win_valid,
    input  logic [IDX_W-1:0] win_idx,
    output logic [N-1:0]     isr_o,
    output logic [IDX_W-1:0] top_idx,
    output logic             top_valid
);

    svc_state_e   state_q, state_d;
    logic [N-1:0] isr_q, isr_d;

    pic_prio_enc #(.N(N), .IDX_W(IDX_W)) u_top_enc (
        .req   (isr_q),
        .idx   (top_idx),
        .found (top_valid)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            isr_q   <= '0;
        end else begin
            state_q <= state_d;
            isr_q   <= isr_d;
        end
    end

    // transitions: ACK_FIRST, ACK_NEST, EOI_LAST, EOI_UNNEST
    always_comb begin
        state_d = state_q;
        isr_d   = isr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ack_go && win_valid) begin
                    isr_d[win_idx] = 1'b1;
                    state_d        = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (ack_go && win_valid) begin
                    isr_d[win_idx] = 1'b1;
                    state_d        = ST_NESTED;
                end else if (eoi_go) begin
                    isr_d[top_idx] = 1'b0;
                    state_d        = ST_IDLE;
                end
            end
            ST_NESTED: begin
                if (ack_go && win_valid) begin
                    isr_d[win_idx] = 1'b1;
                end else if (eoi_go) begin
                    isr_d[top_idx] = 1'b0;
                    if ($countones(isr_q) == 2) state_d = ST_ACTIVE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                isr_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        isr_o = isr_q;
    end

endmodule

// File: rtl/pic_nest_ctrl.sv
module pic_nest_ctrl
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [1:0]         bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               cpu_irq
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    pic_reg_e           reg_sel;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] isr;
    logic [NUM_SRC-1:0] allow;
    logic [NUM_SRC-1:0] qual;
    logic [IDX_W-1:0]   win_idx, top_idx;
    logic               win_valid, top_valid;
    logic               ack_go, eoi_go;
    logic [DATA_W-1:0]  mask_word, vec_word, isr_word;

    assign reg_sel = pic_reg_e'(bus_addr);
    assign ack_go  = bus_wr && (reg_sel == REG_ACK) && bus_wdata[0];
    assign eoi_go  = bus_wr && (reg_sel == REG_EOI) && bus_wdata[0];

    // priority threshold from the in-service register
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_allow
        localparam logic [IDX_W-1:0] GI = IDX_W'(g);
        assign allow[g] = !top_valid || (GI < top_idx);
    end

    assign qual = irq_i & ~mask_q & allow;

    pic_prio_enc #(.N(NUM_SRC), .IDX_W(IDX_W)) u_win_enc (
        .req   (qual),
        .idx   (win_idx),
        .found (win_valid)
    );

    pic_svc_track #(.N(NUM_SRC), .IDX_W(IDX_W)) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_go    (ack_go),
        .eoi_go    (eoi_go),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .isr_o     (isr),
        .top_idx   (top_idx),
        .top_valid (top_valid)
    );

    assign cpu_irq = win_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (bus_wr && (reg_sel == REG_MASK)) begin
            mask_q <= bus_wdata[NUM_SRC-1:0];
        end
    end

    always_comb begin
        mask_word                 = '0;
        mask_word[NUM_SRC-1:0]    = mask_q;
        isr_word                  = '0;
        isr_word[NUM_SRC-1:0]     = isr;
        vec_word                  = '0;
        if (win_valid) begin
            vec_word[DATA_W-1]    = 1'b1;
            vec_word[IDX_W-1:0]   = win_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (reg_sel)
                REG_MASK:   bus_rdata <= mask_word;
                REG_VECTOR: bus_rdata <= vec_word;
                REG_ACK:    bus_rdata <= isr_word;
                REG_EOI:    bus_rdata <= '0;
                default:    bus_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/pic_nest_ctrl_chk.sv
module pic_nest_ctrl_chk #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_i,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] isr,
    input logic               win_valid,
    input logic [IDX_W-1:0]   win_idx,
    input logic               ack_go,
    input logic               eoi_go,
    input logic               cpu_irq
);

    logic [NUM_SRC-1:0] at_or_below;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            at_or_below[i] = (IDX_W'(i) >= win_idx);
        end
    end

    AST_MASKED_NEVER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> !mask_q[win_idx]); // R2

    AST_IRQ_HAS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> irq_i[win_idx]); // R6

    AST_STRICT_ABOVE_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ((isr & ~at_or_below) == '0 && !isr[win_idx])); // R5

    AST_ACK_MARKS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_go && win_valid) |=> isr[$past(win_idx)]); // R4

    AST_ACK_EMPTY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_go && !win_valid) |=> $stable(isr)); // R4

    AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_go && isr != '0) |=> ($countones(isr) + 1 == $countones($past(isr)))); // R7

endmodule

bind pic_nest_ctrl pic_nest_ctrl_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_i     (irq_i),
    .mask_q    (mask_q),
    .isr       (isr),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .ack_go    (ack_go),
    .eoi_go    (eoi_go),
    .cpu_irq   (cpu_irq)
);

// File: tb/pic_nest_ctrl_bench.sv
module pic_nest_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_i = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cpu_irq;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    rd_item_t sb_q[$];

    always #5 clk = ~clk;

    pic_nest_ctrl u_pic_nest_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_i     (irq_i),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq)
    );

    // monitor: compares registered read data against the queue
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                if (sb_q.size() != 0) begin
                    rd_item_t it;
                    it = sb_q.pop_front();
                    total++;
                    if (bus_rdata !== it.exp) begin
                        bad++;
                        $display("FAIL %s: rdata=%h expected=%h", it.tag, bus_rdata, it.exp);
                    end
                end
            end
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        sb_q.push_back('{exp: exp, tag: tag});
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        total++;
        if (cpu_irq !== exp) begin
            bad++;
            $display("FAIL %s: cpu_irq=%b expected=%b", tag, cpu_irq, exp);
        end
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_irq(1'b0, "R1 irq");
        reg_read(2'd0, 8'hFF, "R1 mask");
        reg_read(2'd1, 8'h00, "R1 vector");
        reg_read(2'd2, 8'h00, "R1 isr");
        reg_read(2'd3, 8'h00, "R9 addr3");
        // R2 all masked
        irq_i = 8'h24;
        @(negedge clk);
        chk_irq(1'b0, "R2 masked irq");
        reg_read(2'd1, 8'h00, "R2 masked vector");
        // R9 mask write, R3 / R6 winner
        reg_write(2'd0, 8'h00);
        reg_read(2'd0, 8'h00, "R9 mask readback");
        reg_read(2'd1, 8'h82, "R3 vector src2");
        chk_irq(1'b1, "R6 irq");
        reg_write(2'd0, 8'h04);
        reg_read(2'd1, 8'h85, "R2 vector src5");
        reg_write(2'd0, 8'h00);
        // R4 acknowledge src2
        reg_write(2'd2, 8'h01);
        reg_read(2'd2, 8'h04, "R4 isr src2");
        // R5 equal and lower do not qualify
        reg_read(2'd1, 8'h00, "R5 vector blocked");
        chk_irq(1'b0, "R5 irq blocked");
        // R8 preemption by src1
        irq_i = 8'h26;
        @(negedge clk);
        chk_irq(1'b1, "R8 preempt irq");
        reg_read(2'd1, 8'h81, "R8 vector src1");
        reg_write(2'd2, 8'h01);
        reg_read(2'd2, 8'h06, "R8 isr nested");
        reg_read(2'd1, 8'h00, "R5 vector nested");
        irq_i = 8'h24;
        // R7 eoi restores previous level
        reg_write(2'd3, 8'h01);
        reg_read(2'd2, 8'h04, "R7 isr after eoi");
        reg_read(2'd1, 8'h00, "R8 vector after eoi");
        reg_read(2'd0, 8'h00, "R8 mask untouched");
        reg_write(2'd3, 8'h01);
        reg_read(2'd2, 8'h00, "R7 isr empty");
        reg_read(2'd1, 8'h82, "R7 vector src2 again");
        // R4 ack with nothing qualifying, and bit0 clear
        reg_write(2'd0, 8'hFF);
        reg_write(2'd2, 8'h01);
        reg_read(2'd2, 8'h00, "R4 ack nothing");
        reg_write(2'd3, 8'h01);
        reg_read(2'd2, 8'h00, "R7 eoi when empty");
        reg_write(2'd0, 8'h00);
        reg_write(2'd2, 8'h00);
        reg_read(2'd2, 8'h00, "R4 ack bit0 clear");
        // R10 request rising in the acknowledge cycle
        irq_i = 8'h20;
        @(negedge clk);
        irq_i = 8'h21;
        bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h01;
        @(negedge clk);
        bus_wr = 1'b0;
        reg_read(2'd2, 8'h01, "R10 isr src0");
        chk_irq(1'b0, "R10 irq blocked");
        reg_write(2'd3, 8'h01);
        reg_read(2'd2, 8'h00, "R10 isr cleared");
        // three-deep nesting
        irq_i = 8'h80;
        reg_write(2'd2, 8'h01);
        irq_i = 8'h88;
        reg_write(2'd2, 8'h01);
        irq_i = 8'h89;
        reg_write(2'd2, 8'h01);
        reg_read(2'd2, 8'h89, "R8 isr three deep");
        reg_write(2'd3, 8'h01);
        reg_read(2'd2, 8'h88, "R7 unnest one");
        reg_read(2'd1, 8'h80, "R3 vector src0 again");
        irq_i = 8'h88;
        reg_write(2'd3, 8'h01);
        reg_read(2'd2, 8'h80, "R7 unnest two");
        reg_write(2'd3, 8'h01);
        reg_read(2'd2, 8'h00, "R7 unnest all");
        reg_read(2'd1, 8'h83, "R3 vector src3");
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule